// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide, two-address programming interface of one eight-input interrupt controller. Software writes command bytes to it and reads status from it. The block sorts each write into one of four kinds: an initialisation restart, a run of follow-on initialisation bytes, a priority/end-of-interrupt command, or a read-control command. It keeps the controller's mode state: interrupt mask, vector base, automatic end-of-interrupt, special nesting, rotation, special mask, read selection and poll arming. It returns the selected register or a poll result on reads.

The in-service, request and winner information comes from neighbouring logic, which owns the request latches and the priority resolver. This block does not hold those registers. It tells the neighbours what to change through one-cycle clear masks, a re-evaluate pulse and an output-deassert pulse. For non-specific end-of-interrupt commands, the block finds the highest-priority in-service bit itself, using its own rotation base. Every output is registered, so the effect of a strobe is visible one clock after it.

Top module: `icp_cmd_port`

## Requirements
- R1: After reset, the following are all zero: mask, vector base, rotation base, all mode flags, busy flag, read data and all pulse outputs. The block is in the normal state, with reads of address 0 selecting the request register.
- R2: A write to address 0 with bit 4 set is an init restart. It clears the mask, the vector base, the rotation base, every mode flag, the read selection (back to the request register) and poll arming. It pulses `isr_clr` = 8'hFF and `int_clr`, and sets `init_busy`. It records bit 1 (1 = single, no cascade word) and bit 0 (1 = a final mode word follows).
- R3: After an init restart, writes to address 1 are taken in order. The first is the vector word, which sets `vec_base` = data & 8'hF8. The cascade word comes next, only if bit 1 was 0, and its data is ignored. The mode word comes next, only if bit 0 was 1. After that the block returns to the normal state. `init_busy` is high in every state except normal.
- R4: The mode word sets `sfnm` from data bit 4 and `auto_eoi` from data bit 1.
- R5: In the normal state, a write to address 1 loads `imr` with the data. Without a write, `imr` holds.
- R6: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a read-control command. Bit 2 arms a poll. If bit 1 = 1, bit 0 selects what address 0 reads return: 1 = in-service, 0 = request. If bit 6 = 1, `smm` takes bit 5. If bit 1 or bit 6 is 0, the corresponding state is left unchanged.
- R7: Any other write to address 0 is a priority command, with code = data[7:5]. Codes 0 and 4 set `rot_aeoi` to code bit 2. Code 2 changes nothing and pulses nothing.
- R8: Code 1 clears the highest-priority set bit of `isr_in` through `isr_clr`. Priority runs from `prio_base` upward, modulo 8. If no bit is set, nothing is cleared. Code 5 does the same and also sets `prio_base` to (cleared bit + 1) mod 8.
- R9: Code 3 clears the in-service bit data[2:0]. Code 7 does the same and sets `prio_base` to (data[2:0] + 1) mod 8. Code 6 only sets `prio_base` to (data[2:0] + 1) mod 8.
- R10: Codes 1, 3, 5 and 7, and every poll read, pulse `reeval` for one cycle.
- R11: A read that is not a poll returns the following in `rdata` one cycle after `rd_en`, held until the next read. A read of address 1 returns `imr`. A read of address 0 returns `isr_in` or `irr_in`, according to the selection.
- R12: While a poll is armed, the next read of either address is a poll read, and it disarms the poll. If `win_valid` is high, it returns 8'h80 | `win_idx` and pulses one-hot `irr_clr` and `isr_clr` at bit `win_idx`. If `win_valid` is low, it returns 8'h07 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| isr_in | input | 8 | Current in-service register |
| irr_in | input | 8 | Current request register |
| win_valid | input | 1 | Resolver has an interrupt to deliver |
| win_idx | input | 3 | Input number of the resolver's winner |
| rdata | output | 8 | Registered read data |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| prio_base | output | 3 | Rotation base (input of highest priority) |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| sfnm | output | 1 | Special fully nested mode |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| smm | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialisation sequence in progress |
| isr_clr | output | 8 | One-cycle in-service clear mask |
| irr_clr | output | 8 | One-cycle request clear mask |
| reeval | output | 1 | One-cycle request to re-evaluate interrupts |
| int_clr | output | 1 | One-cycle request to deassert the interrupt output |

## Verification
A wrong sequencer state shows up on the very next address 1 write. That byte lands in the mask instead of the vector base or mode flags, or the reverse. The error is visible at `imr`, `vec_base` or `init_busy` one clock later. A stale rotation base or a wrong priority search shows up as the wrong bit in `isr_clr` on the first non-specific end-of-interrupt after it. Poll arming or read selection that is left set wrongly corrupts `rdata`, and can send a spurious `irr_clr` on the next read. Each of these therefore shows up within one command.

// File: rtl/icp_pkg.sv
`timescale 1ns/1ps
package icp_pkg;
    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] VBASE_MASK = 8'hF8;
    localparam logic [DATA_W-1:0] POLL_HIT   = 8'h80;
    localparam logic [DATA_W-1:0] POLL_NONE  = 8'h07;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_VEC  = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_INIT  = 3'd1,
        K_PRIO  = 3'd2,
        K_RDCTL = 3'd3,
        K_DATA  = 3'd4
    } wr_kind_e;

    typedef enum logic [2:0] {
        C_ROT_CLR  = 3'd0,
        C_NS_EOI   = 3'd1,
        C_NOP      = 3'd2,
        C_SP_EOI   = 3'd3,
        C_ROT_SET  = 3'd4,
        C_ROT_NS   = 3'd5,
        C_SET_BASE = 3'd6,
        C_ROT_SP   = 3'd7
    } prio_cmd_e;

    typedef struct packed {
        logic [NUM_IN-1:0] imr;
        logic [DATA_W-1:0] vbase;
        logic [IDX_W-1:0]  pbase;
        logic              aeoi;
        logic              sfnm;
        logic              raeoi;
        logic              smm;
        logic              sel_isr;
        logic              poll;
        logic [NUM_IN-1:0] isr_clr;
        logic [NUM_IN-1:0] irr_clr;
        logic              reeval;
        logic              int_clr;
        logic [DATA_W-1:0] rdata;
    } port_regs_t;

    typedef struct packed {
        init_st_e st;
        logic     single;
        logic     need_mode;
    } seq_regs_t;
endpackage

// File: rtl/icp_rot_find.sv
`timescale 1ns/1ps
module icp_rot_find #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0]  rot;
    logic [IW-1:0] off;

    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [IW-1:0] pos;
        assign pos    = base + IW'(g);
        assign rot[g] = mask[pos];
    end

    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found = 1'b1;
                off   = IW'(k);
            end
        end
    end

    assign idx = base + off;
endmodule

// File: rtl/icp_cmd_decode.sv
`timescale 1ns/1ps
module icp_cmd_decode
    import icp_pkg::*;
(
    input  logic     wr_en,
    input  logic     addr,
    input  logic     init_bit,
    input  logic     ctl_bit,
    output wr_kind_e kind
);
    always_comb begin
        kind = K_NONE;
        if (wr_en) begin
            if (addr)          kind = K_DATA;
            else if (init_bit) kind = K_INIT;
            else if (ctl_bit)  kind = K_RDCTL;
            else               kind = K_PRIO;
        end
    end
endmodule

// File: rtl/icp_init_seq.sv
`timescale 1ns/1ps
module icp_init_seq
    import icp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     single_in,
    input  logic     need_mode_in,
    input  logic     data_wr,
    output init_st_e state
);
    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (restart) begin
            seq_d.st        = ST_VEC;
            seq_d.single    = single_in;
            seq_d.need_mode = need_mode_in;
        end else if (data_wr) begin
            unique case (seq_q.st)
                ST_VEC:  seq_d.st = !seq_q.single ? ST_CASC :
                                    (seq_q.need_mode ? ST_MODE : ST_NORM);
                ST_CASC: seq_d.st = seq_q.need_mode ? ST_MODE : ST_NORM;
                ST_MODE: seq_d.st = ST_NORM;
                default: seq_d.st = ST_NORM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_NORM, single: 1'b0, need_mode: 1'b0};
        else        seq_q <= seq_d;
    end

    assign state = seq_q.st;
endmodule

// File: rtl/icp_cmd_port.sv
`timescale 1ns/1ps
module icp_cmd_port
    import icp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NUM_IN-1:0] isr_in,
    input  logic [NUM_IN-1:0] irr_in,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_IN-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic [IDX_W-1:0]  prio_base,
    output logic              auto_eoi,
    output logic              sfnm,
    output logic              rot_aeoi,
    output logic              smm,
    output logic              init_busy,
    output logic [NUM_IN-1:0] isr_clr,
    output logic [NUM_IN-1:0] irr_clr,
    output logic              reeval,
    output logic              int_clr
);
    localparam int CMD_LSB = DATA_W - 3;

    port_regs_t regs_d, regs_q;
    wr_kind_e   kind;
    init_st_e   init_st;
    logic       eoi_found;
    logic [IDX_W-1:0] eoi_idx;
    logic [IDX_W-1:0] sel_idx;
    prio_cmd_e  cmd;

    icp_cmd_decode u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .init_bit (wdata[4]),
        .ctl_bit  (wdata[3]),
        .kind     (kind)
    );

    icp_init_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (kind == K_INIT),
        .single_in    (wdata[1]),
        .need_mode_in (wdata[0]),
        .data_wr      (kind == K_DATA),
        .state        (init_st)
    );

    icp_rot_find #(.N(NUM_IN)) u_find (
        .mask  (isr_in),
        .base  (regs_q.pbase),
        .found (eoi_found),
        .idx   (eoi_idx)
    );

    assign sel_idx = wdata[IDX_W-1:0];
    assign cmd     = prio_cmd_e'(wdata[DATA_W-1:CMD_LSB]);

    always_comb begin
        regs_d         = regs_q;
        regs_d.isr_clr = '0;
        regs_d.irr_clr = '0;
        regs_d.reeval  = 1'b0;
        regs_d.int_clr = 1'b0;

        unique case (kind)
            K_INIT: begin
                regs_d.imr     = '0;
                regs_d.vbase   = '0;
                regs_d.pbase   = '0;
                regs_d.aeoi    = 1'b0;
                regs_d.sfnm    = 1'b0;
                regs_d.raeoi   = 1'b0;
                regs_d.smm     = 1'b0;
                regs_d.sel_isr = 1'b0;
                regs_d.poll    = 1'b0;
                regs_d.isr_clr = '1;
                regs_d.int_clr = 1'b1;
            end
            K_RDCTL: begin
                if (wdata[2]) regs_d.poll    = 1'b1;
                if (wdata[1]) regs_d.sel_isr = wdata[0];
                if (wdata[6]) regs_d.smm     = wdata[5];
            end
            K_PRIO: begin
                unique case (cmd)
                    C_ROT_CLR, C_ROT_SET: regs_d.raeoi = cmd[2];
                    C_NS_EOI, C_ROT_NS: begin
                        regs_d.reeval = 1'b1;
                        if (eoi_found) begin
                            regs_d.isr_clr = NUM_IN'(1) << eoi_idx;
                            if (cmd == C_ROT_NS) regs_d.pbase = eoi_idx + 1'b1;
                        end
                    end
                    C_SP_EOI, C_ROT_SP: begin
                        regs_d.reeval  = 1'b1;
                        regs_d.isr_clr = NUM_IN'(1) << sel_idx;
                        if (cmd == C_ROT_SP) regs_d.pbase = sel_idx + 1'b1;
                    end
                    C_SET_BASE: regs_d.pbase = sel_idx + 1'b1;
                    default: ;
                endcase
            end
            K_DATA: begin
                unique case (init_st)
                    ST_NORM: regs_d.imr   = wdata;
                    ST_VEC:  regs_d.vbase = wdata & VBASE_MASK;
                    ST_MODE: begin
                        regs_d.sfnm = wdata[4];
                        regs_d.aeoi = wdata[1];
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase

        if (rd_en) begin
            if (regs_q.poll) begin
                regs_d.poll   = 1'b0;
                regs_d.reeval = 1'b1;
                if (win_valid) begin
                    regs_d.rdata   = POLL_HIT | DATA_W'(win_idx);
                    regs_d.irr_clr = NUM_IN'(1) << win_idx;
                    regs_d.isr_clr = regs_d.isr_clr | (NUM_IN'(1) << win_idx);
                end else begin
                    regs_d.rdata = POLL_NONE;
                end
            end else if (addr) begin
                regs_d.rdata = regs_q.imr;
            end else begin
                regs_d.rdata = regs_q.sel_isr ? isr_in : irr_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rdata     = regs_q.rdata;
    assign imr       = regs_q.imr;
    assign vec_base  = regs_q.vbase;
    assign prio_base = regs_q.pbase;
    assign auto_eoi  = regs_q.aeoi;
    assign sfnm      = regs_q.sfnm;
    assign rot_aeoi  = regs_q.raeoi;
    assign smm       = regs_q.smm;
    assign init_busy = (init_st != ST_NORM);
    assign isr_clr   = regs_q.isr_clr;
    assign irr_clr   = regs_q.irr_clr;
    assign reeval    = regs_q.reeval;
    assign int_clr   = regs_q.int_clr;
endmodule

// File: rtl/icp_cmd_port_chk.sv
`timescale 1ns/1ps
module icp_cmd_port_chk
    import icp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NUM_IN-1:0] imr,
    input logic [IDX_W-1:0]  prio_base,
    input logic              init_busy,
    input logic              int_clr,
    input logic [NUM_IN-1:0] isr_clr,
    input logic [NUM_IN-1:0] irr_clr
);
    assert_icw1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (imr == '0 && init_busy && int_clr && isr_clr == '1));

    assert_imr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !init_busy) |=> (imr == $past(wdata)));

    assert_imr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(imr));

    assert_base_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b11000)
        |=> (prio_base == $past(wdata[2:0]) + 3'd1));

    assert_isr_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clr != '1 && !$past(wr_en && rd_en)) |-> $onehot0(isr_clr));

    assert_isr_clr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clr != '0) |-> ($past(wr_en) || $past(rd_en)));

    assert_irr_clr_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irr_clr));

    assert_irr_clr_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_clr != '0) |-> $past(rd_en));
endmodule

bind icp_cmd_port icp_cmd_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .imr       (imr),
    .prio_base (prio_base),
    .init_busy (init_busy),
    .int_clr   (int_clr),
    .isr_clr   (isr_clr),
    .irr_clr   (irr_clr)
);

// File: tb/icp_cmd_port_tb.sv
`timescale 1ns/1ps
module icp_cmd_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] isr_in = '0;
    logic [7:0] irr_in = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_idx = '0;
    logic [7:0] rdata, imr, vec_base, isr_clr, irr_clr;
    logic [2:0] prio_base;
    logic       auto_eoi, sfnm, rot_aeoi, smm, init_busy, reeval, int_clr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    icp_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .isr_in(isr_in), .irr_in(irr_in),
        .win_valid(win_valid), .win_idx(win_idx), .rdata(rdata), .imr(imr),
        .vec_base(vec_base), .prio_base(prio_base), .auto_eoi(auto_eoi),
        .sfnm(sfnm), .rot_aeoi(rot_aeoi), .smm(smm), .init_busy(init_busy),
        .isr_clr(isr_clr), .irr_clr(irr_clr), .reeval(reeval), .int_clr(int_clr)
    );

    // vector: {is_rd, addr, data[7:0], chk[1:0], exp[7:0]}
    // chk 0 none, 1 rdata, 2 imr, 3 vec_base
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h11, 2'd0, 8'h00},
        {1'b0, 1'b1, 8'h25, 2'd3, 8'h20},
        {1'b0, 1'b1, 8'h04, 2'd0, 8'h00},
        {1'b0, 1'b1, 8'h01, 2'd0, 8'h00},
        {1'b0, 1'b1, 8'hA5, 2'd2, 8'hA5},
        {1'b1, 1'b1, 8'h00, 2'd1, 8'hA5},
        {1'b0, 1'b0, 8'h0B, 2'd0, 8'h00},
        {1'b1, 1'b0, 8'h00, 2'd1, 8'h3C},
        {1'b0, 1'b0, 8'h0A, 2'd0, 8'h00},
        {1'b1, 1'b0, 8'h00, 2'd1, 8'hC3},
        {1'b0, 1'b0, 8'h08, 2'd0, 8'h00},
        {1'b1, 1'b0, 8'h00, 2'd1, 8'hC3},
        {1'b0, 1'b1, 8'h00, 2'd2, 8'h00},
        {1'b1, 1'b1, 8'h00, 2'd1, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 imr", imr, 8'h00);
        chk("R1 vec_base", vec_base, 8'h00);
        chk("R1 prio_base", {5'd0, prio_base}, 8'h00);
        chk("R1 flags", {auto_eoi, sfnm, rot_aeoi, smm, init_busy, reeval, int_clr}, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 clr", isr_clr | irr_clr, 8'h00);

        // vector table
        isr_in = 8'h3C; irr_in = 8'hC3;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) do_rd(VEC[i][18]);
            else            do_wr(VEC[i][18], VEC[i][17:10]);
            case (VEC[i][9:8])
                2'd1: chk("R6 R11 rdata", rdata, VEC[i][7:0]);
                2'd2: chk("R5 imr", imr, VEC[i][7:0]);
                2'd3: chk("R3 vec_base", vec_base, VEC[i][7:0]);
                default: ;
            endcase
        end

        // R2/R3 single, no mode word
        do_wr(1'b0, 8'h12);
        chk("R2 isr_clr all", isr_clr, 8'hFF);
        chk("R2 int_clr", {7'd0, int_clr}, 8'h01);
        chk("R3 busy after restart", {7'd0, init_busy}, 8'h01);
        do_wr(1'b1, 8'h4F);
        chk("R3 vec word", vec_base, 8'h48);
        chk("R3 done after vec", {7'd0, init_busy}, 8'h00);
        do_wr(1'b1, 8'h77);
        chk("R5 imr normal", imr, 8'h77);

        // R3/R4 single with mode word
        do_wr(1'b0, 8'h13);
        chk("R2 imr cleared", imr, 8'h00);
        do_wr(1'b1, 8'h08);
        chk("R3 waits for mode word", {7'd0, init_busy}, 8'h01);
        do_wr(1'b1, 8'h12);
        chk("R4 sfnm aeoi", {6'd0, sfnm, auto_eoi}, 8'h03);
        chk("R4 imr untouched", imr, 8'h00);
        chk("R3 done after mode", {7'd0, init_busy}, 8'h00);

        // R7 rotation flag and no-op
        do_wr(1'b0, 8'h80);
        chk("R7 rot set", {7'd0, rot_aeoi}, 8'h01);
        do_wr(1'b0, 8'h40);
        chk("R7 nop rot", {7'd0, rot_aeoi}, 8'h01);
        chk("R7 nop clr", isr_clr, 8'h00);
        chk("R7 nop reeval base", {reeval, 4'd0, prio_base}, 8'h00);
        do_wr(1'b0, 8'h00);
        chk("R7 rot clear", {7'd0, rot_aeoi}, 8'h00);

        // R8/R9/R10 end of interrupt
        isr_in = 8'h30;
        do_wr(1'b0, 8'h20);
        chk("R8 ns eoi base0", isr_clr, 8'h10);
        chk("R10 reeval eoi", {7'd0, reeval}, 8'h01);
        do_wr(1'b0, 8'hC5);
        chk("R9 set base", {5'd0, prio_base}, 8'h06);
        chk("R9 set base no clr", isr_clr, 8'h00);
        do_wr(1'b0, 8'h20);
        chk("R8 ns eoi base6", isr_clr, 8'h10);
        isr_in = 8'h21;
        do_wr(1'b0, 8'h20);
        chk("R8 ns eoi wrap", isr_clr, 8'h01);
        do_wr(1'b0, 8'hA0);
        chk("R8 rot ns clr", isr_clr, 8'h01);
        chk("R8 rot ns base", {5'd0, prio_base}, 8'h01);
        isr_in = 8'h00;
        do_wr(1'b0, 8'h20);
        chk("R8 empty isr", isr_clr, 8'h00);
        isr_in = 8'h84;
        do_wr(1'b0, 8'h20);
        chk("R8 ns eoi base1", isr_clr, 8'h04);
        do_wr(1'b0, 8'h63);
        chk("R9 specific clr", isr_clr, 8'h08);
        chk("R9 specific base kept", {5'd0, prio_base}, 8'h01);
        do_wr(1'b0, 8'hE7);
        chk("R9 rot specific clr", isr_clr, 8'h80);
        chk("R9 rot specific base", {5'd0, prio_base}, 8'h00);

        // R12 poll
        irr_in = 8'hC3; win_valid = 1'b1; win_idx = 3'd5;
        do_wr(1'b0, 8'h0C);
        do_rd(1'b1);
        chk("R12 poll data", rdata, 8'h85);
        chk("R12 poll irr_clr", irr_clr, 8'h20);
        chk("R12 poll isr_clr", isr_clr, 8'h20);
        chk("R10 reeval poll", {7'd0, reeval}, 8'h01);
        do_rd(1'b1);
        chk("R12 disarmed read", rdata, 8'h00);
        chk("R12 disarmed irr_clr", irr_clr, 8'h00);
        win_valid = 1'b0;
        do_wr(1'b0, 8'h0C);
        do_rd(1'b0);
        chk("R12 poll empty", rdata, 8'h07);
        chk("R12 poll empty irr_clr", irr_clr, 8'h00);

        // R6 special mask
        do_wr(1'b0, 8'h68);
        chk("R6 smm set", {7'd0, smm}, 8'h01);
        do_wr(1'b0, 8'h28);
        chk("R6 smm kept", {7'd0, smm}, 8'h01);
        do_wr(1'b0, 8'h48);
        chk("R6 smm clear", {7'd0, smm}, 8'h00);

        // R2 restart clears modes and selection
        do_wr(1'b0, 8'h80);
        do_wr(1'b0, 8'hC2);
        do_wr(1'b0, 8'h0B);
        do_wr(1'b0, 8'h10);
        chk("R2 modes cleared", {4'd0, sfnm, auto_eoi, rot_aeoi, smm}, 8'h00);
        chk("R2 base cleared", {5'd0, prio_base}, 8'h00);
        chk("R2 vec cleared", vec_base, 8'h00);
        do_wr(1'b1, 8'h00);
        chk("R3 cascade word pending", {7'd0, init_busy}, 8'h01);
        do_wr(1'b1, 8'hFF);
        chk("R3 cascade word ignored", {imr[0], 6'd0, init_busy}, 8'h00);
        isr_in = 8'h3C; irr_in = 8'h5A;
        do_rd(1'b0);
        chk("R2 select back to irr", rdata, 8'h5A);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule